// File: doc/BRIEF.md
# Lane-Partitioned 64-bit Fixed-Point Add/Logic Unit

This block is one fixed-point slice of a vector datapath. It takes two 64-bit operands and either adds or subtracts them, or combines them bitwise. For arithmetic, the 64-bit word is split into independent lanes of 8, 16, 32 or 64 bits. One byte-sliced carry chain is cut at every lane boundary, so each lane computes its own result modulo its width. For example, 16-bit lanes give four unrelated 16-bit sums in a single cycle.

Bitwise operations are only defined for the 32-bit and 64-bit lane settings. In 32-bit mode each half of the word is computed on its own. Every accepted operation produces one registered result, exactly one clock after the input strobe. The result comes with a carry vector and a signed-overflow vector, each holding one bit per byte position. An operation whose encoding is not defined still produces a strobed result, with the data and both flag vectors forced to zero.

Top module: `simd_alu`

## Requirements
- R1: While `rstN` is low and after it is released, `outValid`, `result`, `carryVec` and `ovfVec` are all zero until the first accepted operation.
- R2: An operation is accepted on a rising clock edge where `inValid` is high. `outValid` is high in exactly the cycle after each accepted operation. When `inValid` is low, `outValid` goes low on the next edge and `result`, `carryVec` and `ovfVec` keep their values.
- R3: `laneSel` encodes the lane width as 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. Lanes sit at naturally aligned positions starting at bit 0. With `opSel` = 0 (add), each lane of `result` is (A + B) modulo 2^width, and no carry passes between lanes.
- R4: With `opSel` = 1 (subtract), each lane of `result` is (A − B) modulo 2^width. It is computed as A + ~B + 1, with the +1 injected separately into every lane, and no borrow passes between lanes.
- R5: For add and subtract, `carryVec[i]` holds the carry out of the lane whose most significant byte is byte i (bits 8i+7..8i), and every other bit is zero. For subtract, a carry of 1 means no borrow (A ≥ B unsigned within the lane).
- R6: For add and subtract, `ovfVec[i]` is 1 when the lane whose top byte is byte i overflows as a two's-complement operation; every other bit is zero.
- R7: With `laneSel` set to 2 or 3, `opSel` = 2, 3, 4 and 5 give A AND B, A OR B, A XOR B and A AND NOT B respectively, over all 64 bits. Both flag vectors are zero, and the 32-bit and 64-bit settings give the same result.
- R8: A bitwise opcode (2 to 5) combined with `laneSel` 0 or 1 is undefined. It gives `result`, `carryVec` and `ovfVec` all zero, with `outValid` still set.
- R9: A `laneSel` value of 4 to 7, or an `opSel` value of 6 or 7, is undefined. It gives `result`, `carryVec` and `ovfVec` all zero, with `outValid` still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Input strobe: accept an operation this cycle |
| laneSel | input | 3 | Lane width select (see R3) |
| opSel | input | 3 | Operation select (see R3, R4, R7) |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| result | output | 64 | Registered result |
| carryVec | output | 8 | Per-lane carry out, at each lane's top byte |
| ovfVec | output | 8 | Per-lane signed overflow, at each lane's top byte |
| outValid | output | 1 | High for one cycle per accepted operation |

## Verification
A wrong lane boundary in the decoded mask shows up one cycle after the operation, and only when a carry is actually generated at the faulty boundary. The bench therefore uses operands whose bytes are all ones plus a one, so that every byte produces a carry and any leaked or missing carry changes a result byte and a flag bit together. A wrong carry-in on subtraction makes every lane differ by one. A missing hold of the output registers appears on the first idle cycle, when operands change while `inValid` is low.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  parameter int ALU_W   = 64;
  parameter int SLICE_W = 8;
  localparam int N_SLICE = ALU_W / SLICE_W;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_ANDN = 3'd5
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_AND  = 2'd0,
    LG_OR   = 2'd1,
    LG_XOR  = 2'd2,
    LG_ANDN = 2'd3
  } logicFn_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 load;
    logic                 doArith;
    logic                 doSub;
    logic                 doLogic;
    logicFn_e             logicFn;
    logic [N_SLICE-1:0]   laneEnd;
  } aluCtl_t;

endpackage

// File: rtl/simd_alu_ctrl.sv
module simd_alu_ctrl
  import simd_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SEL_W-1:0] laneSel,
  input  logic [SEL_W-1:0] opSel,
  output aluCtl_t          ctl,
  output logic             outValid
);

  logic laneOk;
  logic wideLane;
  logic isArith;
  logic isLogic;
  logic [N_SLICE-1:0] endMask;
  logic [SEL_W-1:0]   laneBytesM1;

  assign laneOk   = (laneSel < 3'd4);
  assign wideLane = (laneSel == 3'd2) || (laneSel == 3'd3);
  assign isArith  = laneOk && ((opSel == OP_ADD) || (opSel == OP_SUB));
  assign isLogic  = wideLane && (opSel >= OP_AND) && (opSel <= OP_ANDN);

  always_comb begin
    case (laneSel)
      3'd0:    laneBytesM1 = 3'd0;
      3'd1:    laneBytesM1 = 3'd1;
      3'd2:    laneBytesM1 = 3'd3;
      default: laneBytesM1 = 3'd7;
    endcase
  end

  // a byte closes its lane when its index plus one is a lane multiple
  always_comb begin
    for (int i = 0; i < N_SLICE; i++) begin
      endMask[i] = ((3'(i + 1) & laneBytesM1) == 3'd0);
    end
  end

  always_comb begin
    ctl.load    = inValid;
    ctl.doArith = isArith;
    ctl.doSub   = isArith && (opSel == OP_SUB);
    ctl.doLogic = isLogic;
    ctl.laneEnd = endMask;
    case (opSel)
      OP_OR:   ctl.logicFn = LG_OR;
      OP_XOR:  ctl.logicFn = LG_XOR;
      OP_ANDN: ctl.logicFn = LG_ANDN;
      default: ctl.logicFn = LG_AND;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/simd_alu_dp.sv
module simd_alu_dp
  import simd_alu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  aluCtl_t            ctl,
  input  logic [ALU_W-1:0]   opA,
  input  logic [ALU_W-1:0]   opB,
  output logic [ALU_W-1:0]   result,
  output logic [N_SLICE-1:0] carryVec,
  output logic [N_SLICE-1:0] ovfVec
);

  localparam int TOP = SLICE_W - 1;

  logic [ALU_W-1:0]   bEff;
  logic [ALU_W-1:0]   sumW;
  logic [ALU_W-1:0]   logicW;
  logic [N_SLICE-1:0] sliceCy;
  logic [N_SLICE-1:0] sliceOv;

  logic [ALU_W-1:0]   resNext;
  logic [N_SLICE-1:0] cyNext;
  logic [N_SLICE-1:0] ovNext;

  assign bEff = ctl.doSub ? ~opB : opB;

  for (genvar g = 0; g < N_SLICE; g++) begin : g_slice
    logic             cin;
    logic [SLICE_W:0] s;
    if (g == 0) begin : g_first
      assign cin = ctl.doSub;
    end else begin : g_rest
      // carry is cut where the previous byte closed a lane
      assign cin = ctl.laneEnd[g-1] ? ctl.doSub : sliceCy[g-1];
    end
    assign s = {1'b0, opA[g*SLICE_W +: SLICE_W]}
             + {1'b0, bEff[g*SLICE_W +: SLICE_W]}
             + {{SLICE_W{1'b0}}, cin};
    assign sumW[g*SLICE_W +: SLICE_W] = s[SLICE_W-1:0];
    assign sliceCy[g] = s[SLICE_W];
    assign sliceOv[g] = (opA[g*SLICE_W + TOP] == bEff[g*SLICE_W + TOP])
                     && (s[TOP] != opA[g*SLICE_W + TOP]);
  end

  always_comb begin
    case (ctl.logicFn)
      LG_OR:   logicW = opA | opB;
      LG_XOR:  logicW = opA ^ opB;
      LG_ANDN: logicW = opA & ~opB;
      default: logicW = opA & opB;
    endcase
  end

  always_comb begin
    resNext = '0;
    cyNext  = '0;
    ovNext  = '0;
    if (ctl.doArith) begin
      resNext = sumW;
      cyNext  = sliceCy & ctl.laneEnd;
      ovNext  = sliceOv & ctl.laneEnd;
    end else if (ctl.doLogic) begin
      resNext = logicW;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      carryVec <= '0;
      ovfVec   <= '0;
    end else if (ctl.load) begin
      result   <= resNext;
      carryVec <= cyNext;
      ovfVec   <= ovNext;
    end
  end

endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [SEL_W-1:0]   laneSel,
  input  logic [SEL_W-1:0]   opSel,
  input  logic [ALU_W-1:0]   opA,
  input  logic [ALU_W-1:0]   opB,
  output logic [ALU_W-1:0]   result,
  output logic [N_SLICE-1:0] carryVec,
  output logic [N_SLICE-1:0] ovfVec,
  output logic               outValid
);

  aluCtl_t ctl;

  simd_alu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .laneSel  (laneSel),
    .opSel    (opSel),
    .ctl      (ctl),
    .outValid (outValid)
  );

  simd_alu_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .opA      (opA),
    .opB      (opB),
    .result   (result),
    .carryVec (carryVec),
    .ovfVec   (ovfVec)
  );

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
  import simd_alu_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [SEL_W-1:0]   laneSel,
  input logic [SEL_W-1:0]   opSel,
  input logic [ALU_W-1:0]   opA,
  input logic [ALU_W-1:0]   opB,
  input logic [ALU_W-1:0]   result,
  input logic [N_SLICE-1:0] carryVec,
  input logic [N_SLICE-1:0] ovfVec,
  input logic               outValid
);

  logic [N_SLICE-1:0] topMask;
  logic               undefEnc;
  logic               narrowLogic;
  logic               wideAnd;

  always_comb begin
    case (laneSel)
      3'd0:    topMask = 8'hFF;
      3'd1:    topMask = 8'hAA;
      3'd2:    topMask = 8'h88;
      default: topMask = 8'h80;
    endcase
  end

  assign undefEnc    = (laneSel > 3'd3) || (opSel > 3'd5);
  assign narrowLogic = (laneSel < 3'd2) && (opSel >= 3'd2) && (opSel <= 3'd5);
  assign wideAnd     = ((laneSel == 3'd2) || (laneSel == 3'd3)) && (opSel == 3'd2);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result) && $stable(carryVec) && $stable(ovfVec)));

  p_flag_position_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneSel < 3'd4) |=> (((carryVec | ovfVec) & ~$past(topMask)) == '0));

  p_logic_and_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && wideAnd) |=> (result == $past(opA & opB) && carryVec == '0 && ovfVec == '0));

  p_narrow_logic_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && narrowLogic) |=> (outValid && result == '0 && carryVec == '0 && ovfVec == '0));

  p_undefined_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && undefEnc) |=> (outValid && result == '0 && carryVec == '0 && ovfVec == '0));

  // R1: while reset is asserted the outputs are cleared on the next edge
  always @(posedge clk) begin
    if (rstN && !$past(rstN)) begin
      a_reset_clear_r1: assert (!outValid && result == '0 && carryVec == '0 && ovfVec == '0);
    end
  end

endmodule

bind simd_alu simd_alu_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .laneSel  (laneSel),
  .opSel    (opSel),
  .opA      (opA),
  .opB      (opB),
  .result   (result),
  .carryVec (carryVec),
  .ovfVec   (ovfVec),
  .outValid (outValid)
);

// File: tb/tb_simd_alu.sv
`timescale 1ns/1ps
module tb_simd_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  laneSel = '0;
  logic [2:0]  opSel = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [63:0] result;
  logic [7:0]  carryVec;
  logic [7:0]  ovfVec;
  logic        outValid;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  simd_alu dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .laneSel(laneSel), .opSel(opSel),
    .opA(opA), .opB(opB), .result(result), .carryVec(carryVec), .ovfVec(ovfVec),
    .outValid(outValid)
  );

  // reference model built per lane from the requirements
  task automatic model(input logic [2:0] ls, input logic [2:0] op,
                       input logic [63:0] a, input logic [63:0] b,
                       output logic [63:0] r, output logic [7:0] cy, output logic [7:0] ov);
    int w;
    logic [63:0] mask;
    r = '0; cy = '0; ov = '0;
    if (ls > 3 || op > 5) return;
    w = 8 << ls;
    if (op >= 2) begin
      if (ls < 2) return;
      case (op)
        3'd2: r = a & b;
        3'd3: r = a | b;
        3'd4: r = a ^ b;
        default: r = a & ~b;
      endcase
      return;
    end
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int k = 0; k < 64 / w; k++) begin
      logic [64:0] la, lb, t;
      la = {1'b0, (a >> (k * w)) & mask};
      lb = {1'b0, (b >> (k * w)) & mask};
      if (op == 3'd1) lb = {1'b0, ~lb[63:0] & mask};
      t = la + lb + ((op == 3'd1) ? 65'd1 : 65'd0);
      r = r | ((t[63:0] & mask) << (k * w));
      cy[((k + 1) * w) / 8 - 1] = t[w];
      ov[((k + 1) * w) / 8 - 1] = (la[w-1] == lb[w-1]) && (t[w-1] != la[w-1]);
    end
  endtask

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input string req, input logic [2:0] ls, input logic [2:0] op,
                       input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er; logic [7:0] ec, eo;
    model(ls, op, a, b, er, ec, eo);
    @(negedge clk);
    laneSel = ls; opSel = op; opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(req, "outValid", {63'd0, outValid}, 64'd1);
    check(req, "result", result, er);
    check(req, "carryVec", {56'd0, carryVec}, {56'd0, ec});
    check(req, "ovfVec", {56'd0, ovfVec}, {56'd0, eo});
  endtask

  task automatic testReset;
    @(negedge clk);
    check("R1", "outValid", {63'd0, outValid}, 64'd0);
    check("R1", "result", result, 64'd0);
    check("R1", "flags", {48'd0, carryVec, ovfVec}, 64'd0);
  endtask

  task automatic testAdd;   // R3 R5: every byte carries, cut only at lane ends
    for (int ls = 0; ls < 4; ls++) begin
      runOp("R3", 3'(ls), 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
      runOp("R5", 3'(ls), 3'd0, 64'h80FF_7F01_FF00_1234, 64'h80FF_0180_0100_EDCC);
    end
  endtask

  task automatic testSub;   // R4 R5
    for (int ls = 0; ls < 4; ls++) begin
      runOp("R4", 3'(ls), 3'd1, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101);
      runOp("R4", 3'(ls), 3'd1, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
    end
  endtask

  task automatic testOverflow;  // R6
    for (int ls = 0; ls < 4; ls++) begin
      runOp("R6", 3'(ls), 3'd0, 64'h7F7F_7F7F_7F7F_7F7F, 64'h7F7F_7F7F_7F7F_7F7F);
      runOp("R6", 3'(ls), 3'd1, 64'h8080_8080_8080_8080, 64'h0101_0101_0101_0101);
    end
  endtask

  task automatic testLogic;  // R7
    for (int op = 2; op <= 5; op++) begin
      runOp("R7", 3'd2, 3'(op), 64'hF0F0_CCCC_AAAA_1234, 64'hFF00_AAAA_5555_FFFF);
      runOp("R7", 3'd3, 3'(op), 64'hF0F0_CCCC_AAAA_1234, 64'hFF00_AAAA_5555_FFFF);
    end
  endtask

  task automatic testNarrowLogic;  // R8
    runOp("R8", 3'd0, 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    runOp("R8", 3'd1, 3'd4, 64'h1234_5678_9ABC_DEF0, 64'hFFFF);
  endtask

  task automatic testUndefined;  // R9
    runOp("R9", 3'd5, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
    runOp("R9", 3'd7, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF);
    runOp("R9", 3'd3, 3'd6, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
    runOp("R9", 3'd0, 3'd7, 64'hFF, 64'hFF);
  endtask

  task automatic testHold;  // R2: idle inputs change nothing
    runOp("R2", 3'd1, 3'd0, 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040);
    @(negedge clk);
    laneSel = 3'd3; opSel = 3'd0; opA = '1; opB = 64'd1; inValid = 1'b0;
    @(negedge clk);
    check("R2", "outValid idle", {63'd0, outValid}, 64'd0);
    check("R2", "result held", result, 64'h0011_0022_0033_0044);
    check("R2", "carry held", {56'd0, carryVec}, 64'd0);
    @(negedge clk);
    check("R2", "result held 2", result, 64'h0011_0022_0033_0044);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testAdd();
    testSub();
    testOverflow();
    testLogic();
    testNarrowLogic();
    testUndefined();
    testHold();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule